// File: doc/BRIEF.md
# Flash Command Decoder

This block is the command front end of a parallel NOR-style flash controller model. Software issues bus write cycles, each an address and a data byte. The block turns single-cycle and two-cycle command sequences into two kinds of effect. It selects which source a read returns: the memory array, the identifier codes, or the status byte. It also hands erase and program jobs to a downstream write engine. It tracks suspend and resume of a running job. It keeps a command-sequence error flag and a protection error flag, which software can clear. It refuses writes aimed at the boot block unless a protect input or a high-voltage reset input permits them.

Write cycles arrive on a valid/ready stream. A cycle is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Jobs leave on a second valid/ready stream, and that stream has a one-entry holding slot. `cmd_ready` is high when the slot is empty, or when the engine takes the pending job in the same cycle. While the engine holds `req_ready` low, the command stream stalls. The pending job's payload does not change during the stall. Edge capture of the raw strobes happens in the bus adapter upstream, so one stream beat stands for one write cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is array (0), `status_flags` is 000, `req_valid` is 0, both pulse outputs are 0 and `cmd_ready` is 1.
- R2: A command byte of 0xFF selects array read (`rd_mode`=0), 0x90 selects identifier read (1) and 0x70 selects status read (2), whatever the address.
- R3: A byte that is not a defined opcode, received with no sequence open, leaves `rd_mode` and `status_flags` unchanged and issues no job.
- R4: 0x50 clears the sequence error bit `status_flags[0]` and the protection error bit `status_flags[1]`, and leaves `rd_mode` unchanged.
- R5: 0x20 opens an erase. A following 0xD0 whose address bits 18:12 equal those of the 0x20 cycle issues one job with `req_kind`=0 and the second cycle's address. Both cycles set `rd_mode` to status.
- R6: If the cycle after 0x20 is not 0xD0, or carries a different block number in bits 18:12, no job is issued. `status_flags[0]` is set, `rd_mode` becomes status, and that byte is not decoded as a command.
- R7: 0x40 or 0x10 opens a program, and `rd_mode` becomes status. The next cycle issues a job with `req_kind`=1 carrying that cycle's address and data. Its data byte is not decoded as a command.
- R8: An erase or program whose block number (bits 18:12) is 0 issues no job and sets `status_flags[1]`, unless `wp_hi` or `rp_hv` is high. In that case the job is issued.
- R9: 0xB0 sets `rd_mode` to status. If `eng_busy` is high and no suspend is active, it also gives a one-cycle `susp_pulse` and sets `status_flags[2]`. Otherwise no pulse is given.
- R10: 0xD0 with no sequence open and a suspend active gives a one-cycle `resume_pulse`, clears `status_flags[2]` and sets status mode. With no suspend active, it is ignored like R3.
- R11: While `req_valid` is high and `req_ready` is low, the job payload stays stable and `cmd_ready` is low, so no command is taken. When `req_ready` rises, the job retires and a waiting command is taken on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write cycle offered |
| cmd_ready | output | 1 | Write cycle can be taken |
| cmd_addr | input | ADDR_W | Write cycle address |
| cmd_data | input | DATA_W | Write cycle data / opcode |
| wp_hi | input | 1 | Write-protect input high: boot block unlocked |
| rp_hv | input | 1 | Reset input at high voltage: boot block unlocked |
| eng_busy | input | 1 | Write engine is running a job |
| req_valid | output | 1 | Job pending for the engine |
| req_ready | input | 1 | Engine takes the job |
| req_kind | output | 1 | 0 erase, 1 program |
| req_addr | output | ADDR_W | Job address |
| req_data | output | DATA_W | Program data |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| status_flags | output | 3 | [0] sequence error, [1] protection error, [2] suspended |
| susp_pulse | output | 1 | One-cycle suspend request to the engine |
| resume_pulse | output | 1 | One-cycle resume request to the engine |

## Verification
The engine can retire a held job on the same edge that a new write cycle is taken, because `cmd_ready` opens as soon as `req_ready` rises. The bench parks a finished program job with `req_ready` low and offers 0x90 for several cycles. While the job is held, it checks that `cmd_ready` stays low and that the payload and read mode do not change. It then raises `req_ready` with 0x90 still offered. One edge later it expects `req_valid` low and the read mode at identifier, which shows that the retirement and the new command both took effect on a single edge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE      = 2'd0,
    SQ_ERASE_ARM = 2'd1,
    SQ_PROG_ARM  = 2'd2
  } seq_state_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_ARRAY,
    OP_RD_IDENT,
    OP_RD_STATUS,
    OP_CLR_STATUS,
    OP_ERASE_SETUP,
    OP_PROG_SETUP,
    OP_SUSPEND,
    OP_CONFIRM
  } op_e;

  localparam logic KIND_ERASE = 1'b0;
  localparam logic KIND_PROG  = 1'b1;

endpackage

// File: rtl/fcd_opcode_dec.sv
module fcd_opcode_dec
  import fcd_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    case (code)
      8'hFF:        op = OP_RD_ARRAY;
      8'h90:        op = OP_RD_IDENT;
      8'h70:        op = OP_RD_STATUS;
      8'h50:        op = OP_CLR_STATUS;
      8'h20:        op = OP_ERASE_SETUP;
      8'h40, 8'h10: op = OP_PROG_SETUP;
      8'hB0:        op = OP_SUSPEND;
      8'hD0:        op = OP_CONFIRM;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/fcd_boot_guard.sv
module fcd_boot_guard #(
  parameter int BLK_W    = 7,
  parameter int BOOT_BLK = 0
) (
  input  logic [BLK_W-1:0] blk,
  input  logic             wp_hi,
  input  logic             rp_hv,
  output logic             deny
);
  localparam logic [BLK_W-1:0] BOOT_ID = BLK_W'(BOOT_BLK);

  always_comb deny = (blk == BOOT_ID) && !(wp_hi || rp_hv);
endmodule

// File: rtl/fcd_req_slot.sv
module fcd_req_slot #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              free
);
  always_comb free = !req_valid || req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_kind  <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_kind  <= kind_in;
      req_addr  <= addr_in;
      req_data  <= data_in;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // R11: a held job keeps its payload until the engine takes it
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_data) && $stable(req_kind)));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int BLK_LO   = 12,
  parameter int BLK_W    = 7,
  parameter int BOOT_BLK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wp_hi,
  input  logic              rp_hv,
  input  logic              eng_busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        rd_mode,
  output logic [2:0]        status_flags,
  output logic              susp_pulse,
  output logic              resume_pulse
);
  localparam int BLK_HI = BLK_LO + BLK_W - 1;

  seq_state_e       state_q, state_n;
  rd_mode_e         mode_q, mode_n;
  logic             seq_q, seq_n, prot_q, prot_n, susp_q, susp_n;
  logic             sp_q, sp_n, rs_q, rs_n;
  logic [BLK_W-1:0] arm_q, arm_n;
  logic [BLK_W-1:0] blk;
  logic             accept, deny, launch, l_kind, slot_free;
  op_e              op;

  assign blk = cmd_addr[BLK_HI:BLK_LO];

  fcd_opcode_dec u_dec (.code(cmd_data[7:0]), .op(op));

  fcd_boot_guard #(.BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_guard (
    .blk(blk), .wp_hi(wp_hi), .rp_hv(rp_hv), .deny(deny));

  fcd_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(launch), .kind_in(l_kind),
    .addr_in(cmd_addr), .data_in(cmd_data), .req_ready(req_ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .free(slot_free));

  assign cmd_ready = slot_free;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_n = state_q;
    mode_n  = mode_q;
    seq_n   = seq_q;
    prot_n  = prot_q;
    susp_n  = susp_q;
    arm_n   = arm_q;
    sp_n    = 1'b0;
    rs_n    = 1'b0;
    launch  = 1'b0;
    l_kind  = KIND_ERASE;
    if (accept) begin
      case (state_q)
        SQ_ERASE_ARM: begin
          state_n = SQ_IDLE;
          mode_n  = RD_STATUS;
          if (op == OP_CONFIRM && blk == arm_q) begin
            if (deny) prot_n = 1'b1;
            else      launch = 1'b1;
          end else begin
            seq_n = 1'b1;
          end
        end
        SQ_PROG_ARM: begin
          state_n = SQ_IDLE;
          mode_n  = RD_STATUS;
          l_kind  = KIND_PROG;
          if (deny) prot_n = 1'b1;
          else      launch = 1'b1;
        end
        default: begin
          case (op)
            OP_RD_ARRAY:   mode_n = RD_ARRAY;
            OP_RD_IDENT:   mode_n = RD_IDENT;
            OP_RD_STATUS:  mode_n = RD_STATUS;
            OP_CLR_STATUS: begin
              seq_n  = 1'b0;
              prot_n = 1'b0;
            end
            OP_ERASE_SETUP: begin
              state_n = SQ_ERASE_ARM;
              arm_n   = blk;
              mode_n  = RD_STATUS;
            end
            OP_PROG_SETUP: begin
              state_n = SQ_PROG_ARM;
              mode_n  = RD_STATUS;
            end
            OP_SUSPEND: begin
              mode_n = RD_STATUS;
              if (eng_busy && !susp_q) begin
                susp_n = 1'b1;
                sp_n   = 1'b1;
              end
            end
            OP_CONFIRM: begin
              if (susp_q) begin
                susp_n = 1'b0;
                rs_n   = 1'b1;
                mode_n = RD_STATUS;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= RD_ARRAY;
      seq_q   <= 1'b0;
      prot_q  <= 1'b0;
      susp_q  <= 1'b0;
      sp_q    <= 1'b0;
      rs_q    <= 1'b0;
      arm_q   <= '0;
    end else begin
      state_q <= state_n;
      mode_q  <= mode_n;
      seq_q   <= seq_n;
      prot_q  <= prot_n;
      susp_q  <= susp_n;
      sp_q    <= sp_n;
      rs_q    <= rs_n;
      arm_q   <= arm_n;
    end
  end

  assign rd_mode      = mode_q;
  assign status_flags = {susp_q, prot_q, seq_q};
  assign susp_pulse   = sp_q;
  assign resume_pulse = rs_q;

  // R5: a freshly issued job always leaves the interface in status read
  assert_launch_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (rd_mode == RD_STATUS));

  // R8: a refusal and an issued job never come out of the same cycle
  assert_deny_no_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_flags[1]) |-> !$rose(req_valid));

  // R9: the suspend pulse coincides with the suspended flag
  assert_susp_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_pulse |-> (status_flags[2] && !resume_pulse));

  // R10: the resume pulse coincides with the flag dropping
  assert_resume_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (!status_flags[2] && $past(status_flags[2])));

  // R11: a stalled write cycle changes no interface state
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(state_q) && $stable(rd_mode) &&
                                   $stable(status_flags)));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 36;
  localparam int NV = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        wp_hi = 1'b0, rp_hv = 1'b0, eng_busy = 1'b0;
  logic        req_valid, req_ready = 1'b1, req_kind;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic [1:0]  rd_mode;
  logic [2:0]  status_flags;
  logic        susp_pulse, resume_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_hi(wp_hi), .rp_hv(rp_hv),
    .eng_busy(eng_busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .rd_mode(rd_mode), .status_flags(status_flags), .susp_pulse(susp_pulse),
    .resume_pulse(resume_pulse));

  // fields: addr, data, wp, rp, busy, expected mode, expected flags, expected job
  function automatic logic [VW-1:0] mkv(input logic [18:0] a, input logic [7:0] d,
      input logic w, input logic r, input logic b, input logic [1:0] m,
      input logic [2:0] f, input logic q);
    return {a, d, w, r, b, m, f, q};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(19'h01234, 8'h90, 0,0,0, 2'd1, 3'b000, 0), // 0  R2
    mkv(19'h7FFFF, 8'h70, 0,0,0, 2'd2, 3'b000, 0), // 1  R2
    mkv(19'h00055, 8'hFF, 0,0,0, 2'd0, 3'b000, 0), // 2  R2
    mkv(19'h01000, 8'h33, 0,0,0, 2'd0, 3'b000, 0), // 3  R3
    mkv(19'h01000, 8'h90, 0,0,0, 2'd1, 3'b000, 0), // 4  R2
    mkv(19'h01000, 8'h33, 0,0,0, 2'd1, 3'b000, 0), // 5  R3
    mkv(19'h05000, 8'h20, 0,0,0, 2'd2, 3'b000, 0), // 6  R5
    mkv(19'h05234, 8'hD0, 0,0,0, 2'd2, 3'b000, 1), // 7  R5
    mkv(19'h05000, 8'h20, 0,0,0, 2'd2, 3'b000, 0), // 8  R6
    mkv(19'h05000, 8'hFF, 0,0,0, 2'd2, 3'b001, 0), // 9  R6
    mkv(19'h00000, 8'h90, 0,0,0, 2'd1, 3'b001, 0), // 10 R2
    mkv(19'h00000, 8'h50, 0,0,0, 2'd1, 3'b000, 0), // 11 R4
    mkv(19'h02000, 8'h40, 0,0,0, 2'd2, 3'b000, 0), // 12 R7
    mkv(19'h02010, 8'h5A, 0,0,0, 2'd2, 3'b000, 1), // 13 R7
    mkv(19'h00000, 8'h10, 0,0,0, 2'd2, 3'b000, 0), // 14 R8
    mkv(19'h00010, 8'h77, 0,0,0, 2'd2, 3'b010, 0), // 15 R8
    mkv(19'h00000, 8'h10, 0,0,0, 2'd2, 3'b010, 0), // 16 R8
    mkv(19'h00010, 8'h77, 1,0,0, 2'd2, 3'b010, 1), // 17 R8
    mkv(19'h00000, 8'h20, 0,0,0, 2'd2, 3'b010, 0), // 18 R8
    mkv(19'h00000, 8'hD0, 0,1,0, 2'd2, 3'b010, 1), // 19 R8
    mkv(19'h05000, 8'h20, 0,0,0, 2'd2, 3'b010, 0), // 20 R6
    mkv(19'h06000, 8'hD0, 0,0,0, 2'd2, 3'b011, 0), // 21 R6
    mkv(19'h00000, 8'h50, 0,0,0, 2'd2, 3'b000, 0), // 22 R4
    mkv(19'h00000, 8'hB0, 0,0,0, 2'd2, 3'b000, 0), // 23 R9
    mkv(19'h00000, 8'hFF, 0,0,0, 2'd0, 3'b000, 0), // 24 R2
    mkv(19'h00000, 8'hB0, 0,0,1, 2'd2, 3'b100, 0), // 25 R9
    mkv(19'h00000, 8'hFF, 0,0,0, 2'd0, 3'b100, 0), // 26 R9
    mkv(19'h00000, 8'hD0, 0,0,0, 2'd2, 3'b000, 0), // 27 R10
    mkv(19'h00000, 8'hFF, 0,0,0, 2'd0, 3'b000, 0), // 28 R2
    mkv(19'h00000, 8'hD0, 0,0,0, 2'd0, 3'b000, 0), // 29 R10
    mkv(19'h03000, 8'h40, 0,0,0, 2'd2, 3'b000, 0), // 30 R7
    mkv(19'h03000, 8'hFF, 0,0,0, 2'd2, 3'b000, 1)  // 31 R7
  };

  function automatic string tag_of(input int i);
    case (i)
      3, 5:                      return "R3";
      6, 7:                      return "R5";
      8, 9, 20, 21:              return "R6";
      11, 22:                    return "R4";
      12, 13, 30, 31:            return "R7";
      14, 15, 16, 17, 18, 19:    return "R8";
      23, 25, 26:                return "R9";
      27, 29:                    return "R10";
      default:                   return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [18:0] a, input logic [7:0] d,
                      input logic w, input logic r, input logic b);
    @(negedge clk);
    cmd_addr = a; cmd_data = d; wp_hi = w; rp_hv = r; eng_busy = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; wp_hi = 1'b0; rp_hv = 1'b0; eng_busy = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_mode", 32'(rd_mode), 32'd0);
    chk("R1", "flags", 32'(status_flags), 32'd0);
    chk("R1", "req_valid", 32'(req_valid), 32'd0);
    chk("R1", "pulses", 32'({susp_pulse, resume_pulse}), 32'd0);
    chk("R1", "cmd_ready", 32'(cmd_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      send(v[35:17], v[16:9], v[8], v[7], v[6]);
      chk(tag_of(i), "rd_mode", 32'(rd_mode), 32'(v[5:4]));
      chk(tag_of(i), "flags", 32'(status_flags), 32'(v[3:1]));
      chk(tag_of(i), "req_valid", 32'(req_valid), 32'(v[0]));
    end

    // R5 erase payload
    send(19'h05000, 8'h20, 0, 0, 0);
    send(19'h05234, 8'hD0, 0, 0, 0);
    chk("R5", "req_kind", 32'(req_kind), 32'd0);
    chk("R5", "req_addr", 32'(req_addr), 32'h05234);

    // R7 program payload through the alternate setup code
    send(19'h00000, 8'h10, 0, 0, 0);
    send(19'h04321, 8'hA5, 0, 0, 0);
    chk("R7", "req_kind", 32'(req_kind), 32'd1);
    chk("R7", "req_addr", 32'(req_addr), 32'h04321);
    chk("R7", "req_data", 32'(req_data), 32'hA5);

    // R9 / R10 pulse widths
    send(19'h00000, 8'hB0, 0, 0, 1);
    chk("R9", "susp_pulse", 32'(susp_pulse), 32'd1);
    @(negedge clk);
    chk("R9", "susp_pulse width", 32'(susp_pulse), 32'd0);
    send(19'h00000, 8'hB0, 0, 0, 1);
    chk("R9", "second suspend no pulse", 32'(susp_pulse), 32'd0);
    send(19'h00000, 8'hD0, 0, 0, 0);
    chk("R10", "resume_pulse", 32'(resume_pulse), 32'd1);
    chk("R10", "suspended cleared", 32'(status_flags[2]), 32'd0);
    @(negedge clk);
    chk("R10", "resume_pulse width", 32'(resume_pulse), 32'd0);

    // R11 back-pressure, then retirement and acceptance on one edge
    req_ready = 1'b0;
    send(19'h00000, 8'h40, 0, 0, 0);
    send(19'h02222, 8'h3C, 0, 0, 0);
    chk("R11", "job pending", 32'(req_valid), 32'd1);
    cmd_addr = 19'h00000; cmd_data = 8'h90; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "cmd_ready stalled", 32'(cmd_ready), 32'd0);
    chk("R11", "job held", 32'(req_valid), 32'd1);
    chk("R11", "addr stable", 32'(req_addr), 32'h02222);
    chk("R11", "data stable", 32'(req_data), 32'h3C);
    chk("R11", "mode unchanged", 32'(rd_mode), 32'd2);
    req_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", "job retired", 32'(req_valid), 32'd0);
    chk("R11", "command taken", 32'(rd_mode), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule